// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit sits beside the command decoder of a small serial memory with 512 byte locations. It holds the status byte, which combines a volatile write enable latch with two block-protect bits. For every data write the controller presents, it decides whether the write may go ahead. The controller sends it single-cycle strobes: set-enable, clear-enable, status-write with a data byte, and end-of-write. The end-of-write strobe comes when chip select rises after a data write or a status write.

Write permission depends on three things: the active-low hardware protect pin, the enable latch, and an address range check. The two protect bits select none, the top quarter, the top half or the whole array. When the protect pin is driven low, the latch clears at once, without waiting for a clock edge. A low-voltage reset input clears the latch but keeps the protect bits. The bits are held in ordinary flops here, and the system reset loads them with zero. Reads never pass through this unit, so neither the pin nor the protect bits can block them.

Top module: `wprot_unit`

## Requirements
- R1: `status` puts the enable latch at bit 1 and the protect field at bits 3:2 (bit 3 high, bit 2 low). Bits 0 and 7:4 always read 0. After reset, `status` is 0x00.
- R2: A `set_we` strobe sets the latch, visible in `status[1]` after the next clock edge. A `clr_we` strobe clears it.
- R3: While `wp_n` is low, the latch reads 0. It clears as soon as `wp_n` falls, with no clock edge needed, and `set_we` has no effect while `wp_n` is low.
- R4: A `sr_wr` strobe copies `sr_din[3:2]` into the protect field only when the latch is set. With the latch clear, the field does not change. `sr_wr` alone does not clear the latch.
- R5: A `wr_done` strobe clears the latch at the next clock edge.
- R6: An `lv_rst` pulse clears the latch and keeps the protect field. It also blocks a status write presented in the same cycle.
- R7: Protect code 00 protects nothing. 01 protects 0x180–0x1FF, 10 protects 0x100–0x1FF, and 11 protects 0x000–0x1FF.
- R8: `wr_grant` is high exactly when `wr_req` is high, `wp_n` is high, the latch is set and `wr_addr` lies outside the protected range. It is combinational from the current inputs and state.
- R9: When a clearing event (`clr_we`, `wr_done` or `lv_rst`) coincides with `set_we`, the latch ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| lv_rst | input | 1 | Low-voltage reset pulse |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| set_we | input | 1 | Set-enable command strobe |
| clr_we | input | 1 | Clear-enable command strobe |
| sr_wr | input | 1 | Status-write strobe |
| sr_din | input | 8 | Status-write data byte |
| wr_done | input | 1 | End-of-write strobe |
| wr_req | input | 1 | Data write request |
| wr_addr | input | 9 | Data write address |
| status | output | 8 | Status byte |
| wr_grant | output | 1 | Data write permitted |

## Verification
Strobe results appear in `status` one clock edge after the strobe, because the latch and the protect field are each a single register. The bench drives each stimulus at a falling edge. A monitor pops the matching expected item two time units after the next rising edge. `wr_grant` is combinational, so it is probed only in cycles that carry no strobe, where its value stays steady across that edge. The asynchronous clear from `wp_n` is checked one time unit after the pin falls in mid-cycle, before any clock edge.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    PZ_NONE    = 2'b00,
    PZ_QUARTER = 2'b01,
    PZ_HALF    = 2'b10,
    PZ_ALL     = 2'b11
  } pzone_e;

  localparam int STS_W      = 8;
  localparam int STS_WEL    = 1;
  localparam int STS_BP_LO  = 2;
  localparam int STS_BP_HI  = 3;
endpackage

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic clr_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_d;

  always_comb begin
    wel_d = wel_o;
    if (clr_i)      wel_d = 1'b0;
    else if (set_i) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) wel_o <= 1'b0;
    else        wel_o <= wel_d;
  end
endmodule

// File: rtl/wprot_bp.sv
module wprot_bp
  import wprot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_i,
  input  pzone_e din_i,
  output pzone_e zone_o
);
  pzone_e zone_d;

  always_comb begin
    zone_d = zone_o;
    if (ld_i) zone_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zone_o <= PZ_NONE;
    else        zone_o <= zone_d;
  end
endmodule

// File: rtl/wprot_range.sv
module wprot_range
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  pzone_e              zone_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o
);
  logic top_half;
  logic top_qtr;

  assign top_half = addr_i[ADDR_W-1];

  generate
    if (ADDR_W >= 2) begin : g_qtr
      assign top_qtr = &addr_i[ADDR_W-1 -: 2];
    end else begin : g_qtr_small
      assign top_qtr = addr_i[ADDR_W-1];
    end
  endgenerate

  always_comb begin
    unique case (zone_i)
      PZ_NONE:    hit_o = 1'b0;
      PZ_QUARTER: hit_o = top_qtr;
      PZ_HALF:    hit_o = top_half;
      PZ_ALL:     hit_o = 1'b1;
      default:    hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lv_rst,
  input  logic              wp_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              sr_wr,
  input  logic [STS_W-1:0]  sr_din,
  input  logic              wr_done,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [STS_W-1:0]  status,
  output logic              wr_grant
);
  logic   wel;
  logic   wel_clr_n;
  logic   wel_clr;
  logic   bp_ld;
  logic   prot_hit;
  pzone_e zone;
  pzone_e zone_in;

  // Protect pin pulls the latch down without a clock edge.
  assign wel_clr_n = rst_n & wp_n;
  assign wel_clr   = clr_we | wr_done | lv_rst;
  assign bp_ld     = sr_wr & wel & ~lv_rst;
  assign zone_in   = pzone_e'(sr_din[STS_BP_HI:STS_BP_LO]);

  wprot_wel u_wel (
    .clk   (clk),
    .clr_n (wel_clr_n),
    .set_i (set_we),
    .clr_i (wel_clr),
    .wel_o (wel)
  );

  wprot_bp u_bp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (bp_ld),
    .din_i  (zone_in),
    .zone_o (zone)
  );

  wprot_range #(.ADDR_W(ADDR_W)) u_range (
    .zone_i (zone),
    .addr_i (wr_addr),
    .hit_o  (prot_hit)
  );

  always_comb begin
    status                        = '0;
    status[STS_WEL]               = wel;
    status[STS_BP_HI:STS_BP_LO]   = zone;
  end

  assign wr_grant = wr_req & wp_n & wel & ~prot_hit;
endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lv_rst,
  input logic              wp_n,
  input logic              set_we,
  input logic              sr_wr,
  input logic              wr_done,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        status,
  input logic              wr_grant
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:4] == 4'h0) && (status[0] == 1'b0)); // R1

  AST_WP_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !status[1]); // R3

  AST_SR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !status[1]) |=> $stable(status[3:2])); // R4

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !status[1]); // R5

  AST_LV_KEEPS_BP: assert property (@(posedge clk) disable iff (!rst_n)
    lv_rst |=> ($stable(status[3:2]) && !status[1])); // R6

  AST_LV_WINS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_rst && set_we) |=> !status[1]); // R9

  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !wr_grant); // R7

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> (wr_req && wp_n && status[1])); // R8
endmodule

bind wprot_unit wprot_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lv_rst   (lv_rst),
  .wp_n     (wp_n),
  .set_we   (set_we),
  .sr_wr    (sr_wr),
  .wr_done  (wr_done),
  .wr_req   (wr_req),
  .wr_addr  (wr_addr),
  .status   (status),
  .wr_grant (wr_grant)
);

// File: tb/wprot_unit_tb.sv
module wprot_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lv_rst, wp_n, set_we, clr_we, sr_wr, wr_done, wr_req;
  logic [7:0] sr_din;
  logic [8:0] wr_addr;
  logic [7:0] status;
  logic       wr_grant;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] sts;
    logic       gnt;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic       m_wel;
  logic [1:0] m_bp;

  always #5 clk = ~clk;

  wprot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .lv_rst(lv_rst), .wp_n(wp_n),
    .set_we(set_we), .clr_we(clr_we), .sr_wr(sr_wr), .sr_din(sr_din),
    .wr_done(wr_done), .wr_req(wr_req), .wr_addr(wr_addr),
    .status(status), .wr_grant(wr_grant)
  );

  function automatic logic prot(input logic [1:0] bp, input logic [8:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  // Driver: one stimulus per cycle, expected result pushed to the scoreboard.
  task automatic op(input logic s, input logic c, input logic w, input logic [7:0] d,
                    input logic req, input logic [8:0] a, input logic dn,
                    input logic lv, input logic wpn, input string tag);
    exp_t e;
    logic wq;
    @(negedge clk);
    set_we = s; clr_we = c; sr_wr = w; sr_din = d; wr_req = req;
    wr_addr = a; wr_done = dn; lv_rst = lv; wp_n = wpn;
    wq = wpn ? m_wel : 1'b0;
    if (w && wq && !lv) m_bp = d[3:2];
    if (!wpn)             m_wel = 1'b0;
    else if (c || dn || lv) m_wel = 1'b0;
    else if (s)           m_wel = 1'b1;
    e.sts = {4'h0, m_bp, m_wel, 1'b0};
    e.gnt = req & wpn & m_wel & ~prot(m_bp, a);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares after the register update settles.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (status !== e.sts || wr_grant !== e.gnt) begin
          n_bad++;
          $display("FAIL %s: status=%h grant=%b expected status=%h grant=%b",
                   e.tag, status, wr_grant, e.sts, e.gnt);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_wel = 1'b0; m_bp = 2'b00;
    rst_n = 1'b0; lv_rst = 0; wp_n = 1; set_we = 0; clr_we = 0; sr_wr = 0;
    sr_din = 0; wr_done = 0; wr_req = 0; wr_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (status !== 8'h00 || wr_grant !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: status=%h grant=%b expected status=00 grant=0", status, wr_grant);
    end
    @(negedge clk); rst_n = 1'b1;

    //    s c w d      req a       dn lv wpn
    op(0,0,0,8'h00, 0,9'h000, 0,0,1, "R1 idle");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");
    op(0,1,0,8'h00, 0,9'h000, 0,0,1, "R2 clear");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set again");
    op(0,0,1,8'h0C, 0,9'h000, 0,0,1, "R4 load all");
    op(0,0,0,8'h00, 0,9'h000, 1,0,1, "R5 done clears");
    op(0,0,0,8'h00, 1,9'h000, 0,0,1, "R8 no latch");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");
    op(0,0,0,8'h00, 1,9'h000, 0,0,1, "R7 all protected");
    op(0,0,1,8'h04, 0,9'h000, 0,0,1, "R4 load quarter");
    op(0,0,0,8'h00, 1,9'h17F, 0,0,1, "R7 below quarter");
    op(0,0,0,8'h00, 1,9'h180, 0,0,1, "R7 quarter low edge");
    op(0,0,0,8'h00, 1,9'h1FF, 0,0,1, "R7 quarter top");
    op(0,0,1,8'h08, 0,9'h000, 0,0,1, "R4 load half");
    op(0,0,0,8'h00, 1,9'h0FF, 0,0,1, "R7 below half");
    op(0,0,0,8'h00, 1,9'h100, 0,0,1, "R7 half low edge");
    op(0,0,0,8'h00, 0,9'h000, 1,0,1, "R5 done clears");
    op(0,0,1,8'h00, 0,9'h000, 0,0,1, "R4 status write without latch");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");
    op(0,0,0,8'h00, 0,9'h000, 0,1,1, "R6 low voltage");
    op(1,0,1,8'h00, 0,9'h000, 0,1,1, "R6 R9 lv blocks write and set");
    op(1,1,0,8'h00, 0,9'h000, 0,0,1, "R9 set with clear");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");
    op(1,0,0,8'h00, 0,9'h000, 1,0,1, "R9 set with done");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");

    @(negedge clk);
    set_we = 0; wp_n = 1'b0;
    #1;
    n_vec++;
    if (status !== 8'h08) begin
      n_bad++;
      $display("FAIL R3 async clear: status=%h expected status=08", status);
    end
    op(1,0,0,8'h00, 0,9'h000, 0,0,0, "R3 set ignored while pin low");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set after pin high");
    op(0,0,0,8'h00, 1,9'h000, 0,0,0, "R8 pin low blocks grant");
    op(1,0,0,8'h00, 0,9'h000, 0,0,1, "R2 set");
    op(0,0,1,8'hF7, 0,9'h000, 0,0,1, "R1 R4 reserved bits dropped");
    op(0,0,0,8'h00, 1,9'h0AA, 0,0,1, "R8 grant outside quarter");
    op(0,0,1,8'h00, 0,9'h000, 0,0,1, "R4 load none");
    op(0,0,0,8'h00, 1,9'h1FF, 0,0,1, "R7 none protects top");
    op(0,0,0,8'h00, 0,9'h000, 0,0,1, "idle");
    @(negedge clk);
    wr_req = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule